// File: doc/BRIEF.md
# Soft-Start Reference Ramp Generator

This block produces the digital target code that a voltage-mode regulation loop compares its feedback against. After a start request, it first waits for a fixed settling delay. It then raises an internal ramp from zero in fixed increments, one increment every N clock cycles, where N comes from a configuration input. The ramp stops exactly at a programmed 10-bit final reference. The code handed to the error amplifier is the smaller of the ramp and the final reference. Because the ramp only grows, the converter duty cycle opens gradually and inrush current stays bounded.

When the ramp reaches the final reference, a completion flag rises and stays high. From then on the output tracks the final reference directly. Downstream logic uses the flag to arm undervoltage monitoring. A restart pulse, issued for example after a fault, clears the ramp and the flag and runs the delay and ramp again, so the block can be used for repeated retries.

Top module: `ss_ramp_gen`

## Requirements
- R1: While reset is asserted and after it is released, `ref_code_o` is 0 and `ss_done_o` is 0 until a start request has been served.
- R2: With no start pulse, the block stays idle with output 0. A start pulse sampled at a clock edge E0 begins a delay of `DELAY_CYC` cycles, during which the output stays 0.
- R3: The ramp's k-th increment of `STEP_SIZE` appears at edge E0 + `DELAY_CYC` + k·N, where N is `step_period_i`. A period value of 0 behaves as 1.
- R4: The output saturates at `final_ref_i` without overshoot. The last increment is clipped so the output never exceeds the final reference.
- R5: `ss_done_o` rises on the same edge at which the ramp first becomes equal to or greater than `final_ref_i`. With a final reference of 0, it rises at the end of the delay.
- R6: Once high, `ss_done_o` stays high until reset or restart. A start pulse while ramping or done has no effect.
- R7: While `ss_done_o` is high, `ref_code_o` equals the present `final_ref_i`, following any later change to it.
- R8: A restart pulse sampled at an edge sets `ref_code_o` to 0 and `ss_done_o` to 0 at that edge. It then replays the R2 to R5 timeline with that edge taking the place of E0.
- R9: Between restarts, the internal ramp never decreases, and it grows by at most `STEP_SIZE` per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only when idle |
| restart_i | input | 1 | Restart request, clears and re-arms from any state |
| step_period_i | input | PER_W | Cycles per ramp increment (0 treated as 1) |
| final_ref_i | input | REF_W | Final reference code |
| ref_code_o | output | REF_W | Reference code to the error amplifier |
| ss_done_o | output | 1 | Soft-start complete flag |

## Verification
The bench builds the block with `STEP_SIZE` = 4, `DELAY_CYC` = 6 and an 8-bit period, while keeping the 10-bit reference. The wider step makes a clipped final increment reachable, for example 4, 8 and then 10 for a final value of 10. The short delay keeps every timeline only a few hundred cycles long, even at the full-scale code of 1023. With these values, a zero period, a zero final reference, a restart during the ramp and a restart after completion can all be covered by the bench.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
   typedef enum logic [1:0] {
      SS_IDLE  = 2'd0,
      SS_DELAY = 2'd1,
      SS_RAMP  = 2'd2,
      SS_DONE  = 2'd3
   } ss_state_e;
endpackage

// File: rtl/ssr_seq.sv
`timescale 1ns/1ps
module ssr_seq
   import ssr_pkg::*;
#(
   parameter int DELAY_CYC = 1024
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic      restart_i,
   input  logic      final_zero_i,
   input  logic      hit_i,
   output ss_state_e state_o
);
   localparam int DLY_W = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);
   localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_CYC - 1);

   if (DELAY_CYC < 1) begin : g_bad_delay
      $error("ssr_seq: DELAY_CYC must be at least 1");
   end

   ss_state_e       state_q, state_d;
   logic [DLY_W-1:0] dcnt_q, dcnt_d;

   always_comb begin
      state_d = state_q;
      dcnt_d  = dcnt_q;
      if (restart_i) begin
         state_d = SS_DELAY;
         dcnt_d  = '0;
      end else begin
         unique case (state_q)
            SS_IDLE: begin
               if (start_i) begin
                  state_d = SS_DELAY;
                  dcnt_d  = '0;
               end
            end
            SS_DELAY: begin
               if (dcnt_q == DLY_LAST) begin
                  state_d = final_zero_i ? SS_DONE : SS_RAMP;
                  dcnt_d  = '0;
               end else begin
                  dcnt_d = dcnt_q + 1'b1;
               end
            end
            SS_RAMP: begin
               if (hit_i) state_d = SS_DONE;
            end
            SS_DONE: state_d = SS_DONE;
            default: state_d = SS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SS_IDLE;
         dcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         dcnt_q  <= dcnt_d;
      end
   end

   assign state_o = state_q;

   // R6: completion is left only through restart
   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SS_DONE && !restart_i) |=> (state_q == SS_DONE));

   // R8: restart always re-enters the delay phase
   assert_restart_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (state_q == SS_DELAY));
endmodule

// File: rtl/ssr_tick.sv
`timescale 1ns/1ps
module ssr_tick #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [PER_W-1:0] period_i,
   output logic             tick_o
);
   if (PER_W < 1) begin : g_bad_per
      $error("ssr_tick: PER_W must be at least 1");
   end

   logic [PER_W-1:0] cnt_q;
   logic             last;
   logic             short_period;

   assign short_period = (period_i <= PER_W'(1));
   assign last         = short_period || (cnt_q >= period_i - PER_W'(1));
   assign tick_o       = run_i && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run_i || last) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // R3: with a period above one, two ticks never fall on adjacent edges
   assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && period_i > PER_W'(1)) |=> !tick_o);
endmodule

// File: rtl/ssr_accum.sv
`timescale 1ns/1ps
module ssr_accum #(
   parameter int REF_W     = 10,
   parameter int STEP_SIZE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic [REF_W-1:0] final_i,
   output logic [REF_W-1:0] ramp_o,
   output logic             hit_o
);
   localparam int SUM_W = REF_W + 1;

   if (STEP_SIZE < 1 || STEP_SIZE >= (1 << REF_W)) begin : g_bad_step
      $error("ssr_accum: STEP_SIZE out of range");
   end

   logic [REF_W-1:0] ramp_q;
   logic [REF_W-1:0] nxt;
   logic             at_top;

   assign at_top = (ramp_q >= final_i);

   if (STEP_SIZE == 1) begin : g_unit
      assign nxt = at_top ? ramp_q : ramp_q + 1'b1;
   end else begin : g_clamp
      logic [SUM_W-1:0] sum;
      assign sum = {1'b0, ramp_q} + SUM_W'(STEP_SIZE);
      assign nxt = (sum >= {1'b0, final_i}) ? final_i : sum[REF_W-1:0];
   end

   assign hit_o = at_top || (tick_i && (nxt >= final_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ramp_q <= '0;
      else if (clr_i)             ramp_q <= '0;
      else if (tick_i && !at_top) ramp_q <= nxt;
   end

   assign ramp_o = ramp_q;

   // R9: the ramp never falls between restarts
   assert_ramp_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (ramp_q >= $past(ramp_q)));

   // R3: each edge adds at most one step
   assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (int'(ramp_q) - int'($past(ramp_q)) <= STEP_SIZE));

   // R8: restart empties the ramp
   assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (ramp_q == '0));
endmodule

// File: rtl/ss_ramp_gen.sv
`timescale 1ns/1ps
module ss_ramp_gen
   import ssr_pkg::*;
#(
   parameter int REF_W     = 10,
   parameter int PER_W     = 16,
   parameter int STEP_SIZE = 1,
   parameter int DELAY_CYC = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             restart_i,
   input  logic [PER_W-1:0] step_period_i,
   input  logic [REF_W-1:0] final_ref_i,
   output logic [REF_W-1:0] ref_code_o,
   output logic             ss_done_o
);
   if (REF_W < 2) begin : g_bad_ref
      $error("ss_ramp_gen: REF_W must be at least 2");
   end

   ss_state_e        state;
   logic             tick;
   logic             hit;
   logic [REF_W-1:0] ramp;
   logic             run;
   logic             final_zero;

   assign run        = (state == SS_RAMP) && !restart_i;
   assign final_zero = (final_ref_i == '0);

   ssr_seq #(.DELAY_CYC(DELAY_CYC)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .restart_i   (restart_i),
      .final_zero_i(final_zero),
      .hit_i       (hit),
      .state_o     (state)
   );

   ssr_tick #(.PER_W(PER_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run),
      .period_i(step_period_i),
      .tick_o  (tick)
   );

   ssr_accum #(.REF_W(REF_W), .STEP_SIZE(STEP_SIZE)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (restart_i),
      .tick_i (tick),
      .final_i(final_ref_i),
      .ramp_o (ramp),
      .hit_o  (hit)
   );

   assign ss_done_o  = (state == SS_DONE);
   assign ref_code_o = ss_done_o ? final_ref_i
                     : ((ramp < final_ref_i) ? ramp : final_ref_i);

   // R2: the ramp is still empty throughout the delay phase
   assert_delay_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SS_DELAY) |-> (ramp == '0));

   // R8: flag drops on the edge after a restart
   assert_restart_drops_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> !ss_done_o);
endmodule

// File: tb/ss_ramp_gen_bench.sv
`timescale 1ns/1ps
module ss_ramp_gen_bench;
   localparam int REF_W = 10;
   localparam int PER_W = 8;
   localparam int STEP  = 4;
   localparam int DLY   = 6;
   localparam int NVEC  = 7;
   // each row: final reference, step period
   localparam int VEC [NVEC][2] = '{
      '{5, 1}, '{10, 3}, '{0, 4}, '{12, 2}, '{9, 0}, '{1023, 1}, '{37, 5}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic             restart_i = 1'b0;
   logic [PER_W-1:0] step_period_i = '0;
   logic [REF_W-1:0] final_ref_i = '0;
   logic [REF_W-1:0] ref_code_o;
   logic             ss_done_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ss_ramp_gen #(.REF_W(REF_W), .PER_W(PER_W), .STEP_SIZE(STEP), .DELAY_CYC(DLY)) u_ss_ramp_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .restart_i(restart_i),
      .step_period_i(step_period_i), .final_ref_i(final_ref_i),
      .ref_code_o(ref_code_o), .ss_done_o(ss_done_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int done_time(input int f, input int n);
      int ne = (n == 0) ? 1 : n;
      return DLY + ((f + STEP - 1) / STEP) * ne;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 ref in reset", ref_code_o, 0);
      chk("R1 done in reset", ss_done_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // pulse start or restart, then check every cycle up to t_end edges later
   task automatic run_seq(input int f, input int n, input int t_end, input bit via_restart);
      int ne = (n == 0) ? 1 : n;
      int td = done_time(f, n);
      if (via_restart) restart_i = 1'b1; else start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      restart_i = 1'b0;
      for (int t = 0; t <= t_end; t++) begin
         int steps = (t >= DLY) ? (t - DLY) / ne : 0;
         int er = (steps * STEP > f) ? f : steps * STEP;
         string tr, tdn;
         tr  = (via_restart && t == 0) ? "R8 ref after restart"
             : (t < DLY) ? "R2 ref in delay" : (er == f) ? "R4 ref saturated" : "R3 ref step";
         tdn = (via_restart && t == 0) ? "R8 done after restart" : "R5 done";
         chk(tr, ref_code_o, er);
         chk(tdn, ss_done_o, (t >= td) ? 1 : 0);
         if (t < t_end) begin
            @(posedge clk);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1 and R2: reset state and idle without start
      do_reset();
      repeat (5) @(negedge clk);
      chk("R2 idle ref", ref_code_o, 0);
      chk("R2 idle done", ss_done_o, 0);

      // table walk: R3, R4, R5 over several finals and periods
      for (int v = 0; v < NVEC; v++) begin
         final_ref_i   = REF_W'(VEC[v][0]);
         step_period_i = PER_W'(VEC[v][1]);
         do_reset();
         run_seq(VEC[v][0], VEC[v][1], done_time(VEC[v][0], VEC[v][1]) + 3, 1'b0);
      end

      // R6: sticky done, start ignored after completion
      final_ref_i = 10'd12;
      step_period_i = 8'd2;
      do_reset();
      run_seq(12, 2, done_time(12, 2) + 1, 1'b0);
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 20; i++) begin
         chk("R6 done sticky", ss_done_o, 1);
         chk("R6 start ignored ref", ref_code_o, 12);
         @(negedge clk);
      end

      // R7: output follows final reference once done
      final_ref_i = 10'd20;
      #1;
      chk("R7 follows final up", ref_code_o, 20);
      final_ref_i = 10'd3;
      #1;
      chk("R7 follows final down", ref_code_o, 3);
      chk("R7 done kept", ss_done_o, 1);

      // R8: restart after completion replays the timeline
      final_ref_i = 10'd16;
      step_period_i = 8'd3;
      run_seq(16, 3, done_time(16, 3) + 2, 1'b1);

      // R8 and R6: restart mid-ramp, start mid-ramp ignored
      final_ref_i = 10'd40;
      step_period_i = 8'd2;
      do_reset();
      run_seq(40, 2, DLY + 9, 1'b0);
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk("R6 start ignored in ramp", ref_code_o, 20);
      run_seq(40, 2, done_time(40, 2) + 2, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule